// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This controller takes an external stereo audio codec from cold power-on to normal operation with its internal PLL locked to an external reference clock. After a start pulse it pulses the codec's active-low power-down/reset line. It then issues a fixed, ordered series of control-register writes, waits out the reference settling and PLL lock intervals, and finally opens the gate for the audio bit clock and frame clock.

Register writes are passed one at a time to a separate control-bus master, such as an I2C or 3-wire engine, over a request/acknowledge port. Each address/data pair is held steady with the request raised until the master acknowledges it. All wait intervals come from counters sized from the system clock frequency, and each is rounded up so that the codec's minimum times are always met.

The state machine has seven states. `ST_IDLE` holds the codec in reset. `ST_RST_LOW` times the reset pulse. `ST_WRITE` presents one write and waits for its acknowledge. `ST_VREF_WAIT` times reference settling. `ST_LOCK_WAIT` times PLL lock. `ST_CLK_ON` opens the audio clock gate. `ST_RUNNING` raises the done flag. The transitions are:
- start: `ST_IDLE`/`ST_RUNNING` → `ST_RST_LOW`.
- reset timer expired: → `ST_WRITE` (step 0).
- acknowledge on steps 0–2: `ST_WRITE` → `ST_WRITE` with the next step.
- acknowledge on step 3: → `ST_VREF_WAIT`.
- settle timer expired: → `ST_WRITE` (step 4).
- acknowledge on step 4: → `ST_LOCK_WAIT`.
- lock timer expired: → `ST_CLK_ON`.
- unconditionally: `ST_CLK_ON` → `ST_RUNNING`.

Top module: `codec_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a start pulse arrives, `codec_pdn_n`, `wr_req`, `aif_clk_en` and `seq_done` are all low.
- R2: A start pulse seen in idle or running drives `codec_pdn_n` low for at least ceil(RST_LOW_NS·CLK_HZ/1e9) cycles and at most two cycles more. The line then goes high.
- R3: The first write after reset release is the dummy access: address `DUMMY_ADDR`, data `DUMMY_DATA` (both default 8'h00).
- R4: The next three writes go in this order: address 8'h05 with data 8'h42, address 8'h06 with data 8'h0D, then address 8'h00 with data 8'h40.
- R5: `wr_req` is only ever high while `codec_pdn_n` is high. While a write waits for `wr_ack`, its address and data are held unchanged. Each acknowledged write advances exactly one step, so exactly five writes are made per sequence.
- R6: After the acknowledge of the 8'h00/8'h40 write, at least ceil(VREF_WAIT_US·CLK_HZ/1e6) cycles pass before the next write is acknowledged.
- R7: The fifth and last write is address 8'h01 with data 8'h03.
- R8: `aif_clk_en` rises at least ceil(LOCK_WAIT_US·CLK_HZ/1e6) cycles and at most three cycles more after the final write's acknowledge. It is never high while `wr_req` is high or while `codec_pdn_n` is low.
- R9: `seq_done` rises exactly one cycle after `aif_clk_en`, and both then stay high.
- R10: A start pulse while the sequence is in progress has no effect. `codec_pdn_n` does not fall, and the sequence runs on to the end.
- R11: A start pulse while done restarts the sequence. In the next cycle `codec_pdn_n`, `aif_clk_en` and `seq_done` are all low, and then all five writes are repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous-domain reset |
| start | input | 1 | One-cycle pulse to begin or restart bring-up |
| wr_ack | input | 1 | Acknowledge from the control-bus master for the current write |
| codec_pdn_n | output | 1 | Codec power-down/reset line, active low |
| wr_addr | output | 8 | Register address of the pending write |
| wr_data | output | 8 | Register data of the pending write |
| wr_req | output | 1 | Write request, held until acknowledged |
| aif_clk_en | output | 1 | Enable for the audio bit clock and frame clock |
| seq_done | output | 1 | Bring-up complete |

## Verification
Every output is decoded directly from the state register, so each result appears in the first cycle after the clock edge that consumes its cause. After a start in running, the reset line, clock enable and done flag all drop one cycle later. After the final acknowledge, the clock enable is due LOCK+2 cycles later and done one cycle after that. After the reference write's acknowledge, the next acknowledge lands VREF+2+latency cycles later. The bench logs the cycle number of every acknowledge and output edge on the falling clock edge and compares the gaps against windows that start at the rounded-up minimum and allow only those pipeline cycles. Level checks are sampled 1 ns after a rising edge.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_WRITE,
        ST_VREF_WAIT,
        ST_LOCK_WAIT,
        ST_CLK_ON,
        ST_RUNNING
    } seq_state_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } reg_wr_t;

    // Write steps: 0 dummy, 1 format, 2 PLL/rate, 3 reference power-up, 4 PLL enable
    localparam int unsigned STEP_CNT  = 5;
    localparam int unsigned STEP_VREF = 3;
    localparam int unsigned STEP_PLL  = 4;

endpackage

// File: rtl/codec_step_rom.sv
module codec_step_rom
    import codec_seq_pkg::*;
#(
    parameter logic [7:0] DUMMY_ADDR = 8'h00,
    parameter logic [7:0] DUMMY_DATA = 8'h00,
    parameter int unsigned IDX_W     = 3
) (
    input  logic [IDX_W-1:0] idx,
    output reg_wr_t          wr
);

    always_comb begin
        unique case (idx)
            IDX_W'(0): wr = '{addr: DUMMY_ADDR, data: DUMMY_DATA};
            IDX_W'(1): wr = '{addr: 8'h05, data: 8'h42};
            IDX_W'(2): wr = '{addr: 8'h06, data: 8'h0D};
            IDX_W'(3): wr = '{addr: 8'h00, data: 8'h40};
            IDX_W'(4): wr = '{addr: 8'h01, data: 8'h03};
            default:   wr = '{addr: DUMMY_ADDR, data: DUMMY_DATA};
        endcase
    end

endmodule

// File: rtl/codec_wait_timer.sv
module codec_wait_timer #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/codec_bringup_seq.sv
module codec_bringup_seq
    import codec_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 100_000_000,
    parameter int unsigned RST_LOW_NS    = 150,
    parameter int unsigned VREF_WAIT_US  = 3000,
    parameter int unsigned LOCK_WAIT_US  = 10000,
    parameter logic [7:0]  DUMMY_ADDR    = 8'h00,
    parameter logic [7:0]  DUMMY_DATA    = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wr_ack,
    output logic       codec_pdn_n,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       wr_req,
    output logic       aif_clk_en,
    output logic       seq_done
);

    // Cycle counts, rounded up so each minimum time is met
    localparam logic [63:0] HZ64     = 64'(CLK_HZ);
    localparam logic [63:0] RST_RAW  = (64'(RST_LOW_NS) * HZ64 + 64'd999_999_999) / 64'd1_000_000_000;
    localparam logic [63:0] VREF_RAW = (64'(VREF_WAIT_US) * HZ64 + 64'd999_999) / 64'd1_000_000;
    localparam logic [63:0] LOCK_RAW = (64'(LOCK_WAIT_US) * HZ64 + 64'd999_999) / 64'd1_000_000;
    localparam logic [63:0] RST_CYC  = (RST_RAW  == 64'd0) ? 64'd1 : RST_RAW;
    localparam logic [63:0] VREF_CYC = (VREF_RAW == 64'd0) ? 64'd1 : VREF_RAW;
    localparam logic [63:0] LOCK_CYC = (LOCK_RAW == 64'd0) ? 64'd1 : LOCK_RAW;
    localparam logic [63:0] MAX_A    = (RST_CYC > VREF_CYC) ? RST_CYC : VREF_CYC;
    localparam logic [63:0] MAX_CYC  = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 64'd1);
    localparam int unsigned IDX_W    = $clog2(STEP_CNT);
    localparam logic [CNT_W-1:0] RST_LD  = CNT_W'(RST_CYC);
    localparam logic [CNT_W-1:0] VREF_LD = CNT_W'(VREF_CYC);
    localparam logic [CNT_W-1:0] LOCK_LD = CNT_W'(LOCK_CYC);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    reg_wr_t          step_wr;

    codec_wait_timer #(.CNT_W(CNT_W)) wait_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    codec_step_rom #(
        .DUMMY_ADDR (DUMMY_ADDR),
        .DUMMY_DATA (DUMMY_DATA),
        .IDX_W      (IDX_W)
    ) step_rom_i (
        .idx (idx_q),
        .wr  (step_wr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next-state and timer load
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE, ST_RUNNING: begin
                if (start) begin
                    state_d  = ST_RST_LOW;
                    idx_d    = '0;
                    tmr_load = 1'b1;
                    tmr_val  = RST_LD;
                end
            end
            ST_RST_LOW: begin
                if (tmr_expired) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_ack) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == IDX_W'(STEP_VREF)) begin
                        state_d  = ST_VREF_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = VREF_LD;
                    end else if (idx_q == IDX_W'(STEP_PLL)) begin
                        state_d  = ST_LOCK_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = LOCK_LD;
                    end
                end
            end
            ST_VREF_WAIT: begin
                if (tmr_expired) state_d = ST_WRITE;
            end
            ST_LOCK_WAIT: begin
                if (tmr_expired) state_d = ST_CLK_ON;
            end
            ST_CLK_ON: state_d = ST_RUNNING;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        codec_pdn_n = (state_q != ST_IDLE) && (state_q != ST_RST_LOW);
        wr_req      = (state_q == ST_WRITE);
        aif_clk_en  = (state_q == ST_CLK_ON) || (state_q == ST_RUNNING);
        seq_done    = (state_q == ST_RUNNING);
        wr_addr     = step_wr.addr;
        wr_data     = step_wr.data;
    end

    // R5: no request while the codec is held in reset
    a_r5_req_needs_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> codec_pdn_n);

    // R5: pending write is held until acknowledged
    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R8: audio clocks only with codec out of reset and no write pending
    a_r8_clk_gate_safe: assert property (@(posedge clk) disable iff (!rst_n)
        aif_clk_en |-> (codec_pdn_n && !wr_req));

    // R9: done follows the clock enable
    a_r9_done_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(aif_clk_en));

    // R10: start ignored mid-sequence
    a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (codec_pdn_n && !seq_done && start) |=> codec_pdn_n);

    // R11: start when done drops everything next cycle
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && start) |=> (!codec_pdn_n && !aif_clk_en && !seq_done));

endmodule

// File: tb/codec_bringup_seq_tb_top.sv
module codec_bringup_seq_tb_top;

    localparam int unsigned CLK_HZ  = 200_000_000;
    localparam int unsigned RST_NS  = 150;
    localparam int unsigned VREF_US = 3;
    localparam int unsigned LOCK_US = 10;
    localparam int RST_MIN  = (RST_NS * 200 + 999) / 1000;   // 30
    localparam int VREF_MIN = VREF_US * 200;                 // 600
    localparam int LOCK_MIN = LOCK_US * 200;                 // 2000
    localparam logic [15:0] EXP_WR [0:4] = '{16'h0000, 16'h0542, 16'h060D, 16'h0040, 16'h0103};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       wr_ack = 1'b0;
    logic       codec_pdn_n, wr_req, aif_clk_en, seq_done;
    logic [7:0] wr_addr, wr_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int ack_lat = 2;
    int lat_cnt = 0;
    int n_wr = 0;
    logic [15:0] cap_wr [0:7];
    int ack_cyc [0:7];
    int low_run = 0, low_last = 0, falls = 0;
    int clken_cyc = 0, done_cyc = 0;
    logic pdn_prev = 1'b0, clk_prev = 1'b0, done_prev = 1'b0;
    int wd = 0;

    always #2.5 clk = ~clk;

    codec_bringup_seq #(
        .CLK_HZ       (CLK_HZ),
        .RST_LOW_NS   (RST_NS),
        .VREF_WAIT_US (VREF_US),
        .LOCK_WAIT_US (LOCK_US),
        .DUMMY_ADDR   (8'h00),
        .DUMMY_DATA   (8'h00)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .wr_ack      (wr_ack),
        .codec_pdn_n (codec_pdn_n),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_req      (wr_req),
        .aif_clk_en  (aif_clk_en),
        .seq_done    (seq_done)
    );

    // Bus-master model and edge monitor, on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wr_ack) begin
            wr_ack = 1'b0;
        end else if (wr_req) begin
            if (lat_cnt >= ack_lat) begin
                wr_ack = 1'b1;
                if (n_wr < 8) begin
                    cap_wr[n_wr]  = {wr_addr, wr_data};
                    ack_cyc[n_wr] = cyc;
                end
                n_wr = n_wr + 1;
                lat_cnt = 0;
            end else begin
                lat_cnt = lat_cnt + 1;
            end
        end
        if (start) low_run = 0;
        else if (!codec_pdn_n) low_run = low_run + 1;
        if (codec_pdn_n && !pdn_prev) low_last = low_run;
        if (!codec_pdn_n && pdn_prev) falls = falls + 1;
        if (aif_clk_en && !clk_prev) clken_cyc = cyc;
        if (seq_done && !done_prev) done_cyc = cyc;
        pdn_prev  = codec_pdn_n;
        clk_prev  = aif_clk_en;
        done_prev = seq_done;
    end

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!seq_done) tick();
        tick();
    endtask

    // Walk the expected-write table and timing windows for one run
    task automatic check_run();
        chk(n_wr == 5, "R5 write count", n_wr, 5);
        chk(low_last >= RST_MIN && low_last <= RST_MIN + 2, "R2 reset low cycles", low_last, RST_MIN);
        for (int k = 0; k < 5; k++) begin
            if (k == 0)      chk(cap_wr[k] == EXP_WR[k], "R3 dummy write", cap_wr[k], EXP_WR[k]);
            else if (k == 4) chk(cap_wr[k] == EXP_WR[k], "R7 PLL enable write", cap_wr[k], EXP_WR[k]);
            else             chk(cap_wr[k] == EXP_WR[k], "R4 setup write", cap_wr[k], EXP_WR[k]);
        end
        chk(ack_cyc[4] - ack_cyc[3] >= VREF_MIN && ack_cyc[4] - ack_cyc[3] <= VREF_MIN + ack_lat + 3,
            "R6 reference settle gap", ack_cyc[4] - ack_cyc[3], VREF_MIN);
        chk(clken_cyc - ack_cyc[4] >= LOCK_MIN && clken_cyc - ack_cyc[4] <= LOCK_MIN + 3,
            "R8 lock gap", clken_cyc - ack_cyc[4], LOCK_MIN);
        chk(done_cyc - clken_cyc == 1, "R9 done after clock enable", done_cyc - clken_cyc, 1);
        chk(seq_done && aif_clk_en && codec_pdn_n, "R9 held high", {seq_done, aif_clk_en, codec_pdn_n}, 3'b111);
    endtask

    initial begin
        // R1: reset state
        repeat (4) tick();
        chk(!codec_pdn_n, "R1 pdn in reset", codec_pdn_n, 0);
        chk(!wr_req && !aif_clk_en && !seq_done, "R1 outputs in reset",
            {wr_req, aif_clk_en, seq_done}, 0);
        rst_n = 1'b1;
        repeat (5) tick();
        chk(!codec_pdn_n && !wr_req && !aif_clk_en && !seq_done, "R1 idle before start",
            {codec_pdn_n, wr_req, aif_clk_en, seq_done}, 0);

        // Run 1: ack latency 2, stray start mid-sequence
        ack_lat = 2;
        pulse_start();
        while (n_wr < 4) tick();
        repeat (3) tick();
        pulse_start();
        tick();
        chk(codec_pdn_n && !wr_req, "R10 start ignored while settling", codec_pdn_n, 1);
        wait_done();
        check_run();
        chk(falls == 0, "R10 no reset pulse from stray start", falls, 0);

        // Run 2: restart from done, ack latency 0
        n_wr = 0;
        ack_lat = 0;
        pulse_start();
        chk(!codec_pdn_n && !aif_clk_en && !seq_done, "R11 restart drops outputs",
            {codec_pdn_n, aif_clk_en, seq_done}, 0);
        wait_done();
        check_run();
        chk(falls == 1, "R11 one reset pulse on restart", falls, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule